// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Decimal Mode

This combinational unit carries out the arithmetic for an accumulator-based processor. It takes the accumulator, a second operand, the incoming carry flag, a decimal-mode flag and a two-bit operation code. It returns a result word, an outgoing carry, and zero and sign indications. The default width is 16 bits, which is four 4-bit digits.

It supports three operations. Add with carry leaves the second operand as it is. Subtract with carry treats a carry of 1 as "no borrow". Rotate right moves the accumulator and the carry together as one wider quantity. When decimal mode is set, the operands are packed BCD and every 4-bit digit of an add or subtract is corrected back into the range 0 to 9. For subtract in decimal mode, the second operand is first replaced by its nine's complement instead of its one's complement.

The surrounding core decodes instructions, fetches operands and stores flags. This unit does none of that. Its outputs are valid in the same cycle its inputs are.

Top module: `acc_alu`

## Requirements
- R1: With op 2'b00 and decimal flag 0, {carry_o, result_o} equals acc_i + opb_i + carry_i as a 17-bit sum.
- R2: With op 2'b01 and decimal flag 0, result_o equals (acc_i + ~opb_i + carry_i) mod 2^16. carry_o is 1 exactly when acc_i >= opb_i + (1 - carry_i), so a carry of 0 takes one extra unit away.
- R3: With op 2'b00 and decimal flag 1, each operand holds four packed BCD digits, with bits 3:0 as the least significant digit. result_o is the BCD form of (A + B + carry_i) mod 10000, and carry_o is 1 when that sum reaches 10000. Digit carries propagate from lower digits to higher ones.
- R4: With op 2'b01 and decimal flag 1, result_o is the BCD form of (A - B - (1 - carry_i)) mod 10000. carry_o is 1 exactly when no borrow occurs.
- R5: With op 2'b10, result_o equals {carry_i, acc_i[15:1]} and carry_o equals acc_i[0]. The decimal flag and opb_i have no effect.
- R6: With op 2'b11, result_o equals acc_i and carry_o equals carry_i.
- R7: zero_o is 1 exactly when result_o is all zeros.
- R8: sign_o equals result_o[15].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 16 | Accumulator operand |
| opb_i | input | 16 | Second operand |
| carry_i | input | 1 | Incoming carry flag (1 = no borrow for subtract) |
| dec_i | input | 1 | Decimal mode: 1 selects packed BCD arithmetic |
| op_i | input | 2 | 00 add, 01 subtract, 10 rotate right, 11 pass |
| result_o | output | 16 | Result word |
| carry_o | output | 1 | Outgoing carry flag |
| zero_o | output | 1 | Result is zero |
| sign_o | output | 1 | Copy of result bit 15 |

## Verification
Binary add and subtract are tried with both carry-in values and with operands that wrap the word, such as 0xFFFF + 1 and 0 - 1. These separate correct full-width carry and borrow from wrong ones, and they show whether a carry of 0 really takes one extra unit away. In decimal mode the operands are chosen so that a single digit overflows, a carry ripples through all four digits (9999 + 1), and a subtraction borrows across every digit (0000 - 0001). These cases expose a missing +6 correction, a digit carry that is lost, or a one's complement used where a nine's complement is needed. Rotate is run with the decimal flag set and cleared and with both carry-in values, which confirms that the carry enters bit 15 and that decimal mode has no effect on it.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] acc_i,
  input  logic [4*DIGITS-1:0] opb_i,
  input  logic                carry_i,
  input  logic                dec_i,
  input  logic [1:0]          op_i,
  output logic [4*DIGITS-1:0] result_o,
  output logic                carry_o,
  output logic                zero_o,
  output logic                sign_o
);
  localparam int W = 4 * DIGITS;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_ROR  = 2'b10,
    OP_PASS = 2'b11
  } op_e;

  op_e op;
  assign op = op_e'(op_i);

  logic         is_sub;
  logic [W-1:0] arith_res;
  logic [DIGITS:0] dcarry;

  assign is_sub    = (op == OP_SUB);
  assign dcarry[0] = carry_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] a_d, b_d, b_eff;
    logic [4:0] raw, adj;
    logic       fix;
    assign a_d   = acc_i[4*g +: 4];
    assign b_d   = opb_i[4*g +: 4];
    assign b_eff = !is_sub ? b_d : (dec_i ? 4'd9 - b_d : ~b_d);
    assign raw   = {1'b0, a_d} + {1'b0, b_eff} + {4'b0, dcarry[g]};
    assign fix   = dec_i && (raw > 5'd9);
    assign adj   = raw + (fix ? 5'd6 : 5'd0);
    assign arith_res[4*g +: 4] = adj[3:0];
    assign dcarry[g+1] = dec_i ? fix : raw[4];
  end

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: begin result_o = arith_res;            carry_o = dcarry[DIGITS]; end
      OP_ROR:         begin result_o = {carry_i, acc_i[W-1:1]}; carry_o = acc_i[0];     end
      default:        begin result_o = acc_i;                carry_o = carry_i;        end
    endcase
  end

  assign zero_o = (result_o == '0);
  assign sign_o = result_o[W-1];

  function automatic logic all_bcd(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  always_comb begin
    if (!$isunknown({acc_i, opb_i, carry_i, dec_i, op_i})) begin
      if (op_i == 2'b00 && !dec_i)
        p_binadd_r1: assert ({carry_o, result_o} == {1'b0, acc_i} + {1'b0, opb_i} + {{W{1'b0}}, carry_i})
          else $error("binary add mismatch");
      if (op_i == 2'b01 && !dec_i)
        p_binsub_r2: assert (result_o == W'(acc_i - opb_i - {{(W-1){1'b0}}, !carry_i}))
          else $error("binary subtract mismatch");
      if (op_i[1] == 1'b0 && dec_i && all_bcd(acc_i) && all_bcd(opb_i))
        p_bcd_digits_r3: assert (all_bcd(result_o))
          else $error("decimal result holds a non-decimal digit");
      if (op_i == 2'b10)
        p_rotate_r5: assert (result_o[W-1] == carry_i && result_o[W-2:0] == acc_i[W-1:1] && carry_o == acc_i[0])
          else $error("rotate mismatch");
      if (op_i == 2'b11)
        p_pass_r6: assert (result_o == acc_i && carry_o == carry_i)
          else $error("pass mismatch");
    end
  end
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] acc, opb, res;
  logic        cin, dec, cout, zf, sf;
  logic [1:0]  op;

  acc_alu dut (
    .acc_i(acc), .opb_i(opb), .carry_i(cin), .dec_i(dec), .op_i(op),
    .result_o(res), .carry_o(cout), .zero_o(zf), .sign_o(sf)
  );

  typedef struct {
    logic [15:0] r;
    logic        c;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int bcd2int(input logic [15:0] v);
    return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction

  function automatic logic [15:0] int2bcd(input int n);
    logic [15:0] v;
    v[3:0]   = 4'(n % 10);
    v[7:4]   = 4'((n / 10) % 10);
    v[11:8]  = 4'((n / 100) % 10);
    v[15:12] = 4'((n / 1000) % 10);
    return v;
  endfunction

  task automatic drive(input logic [1:0] o, input logic d, input logic [15:0] a,
                       input logic [15:0] b, input logic c, input string tag);
    exp_t e;
    int s;
    @(negedge clk);
    acc = a; opb = b; cin = c; dec = d; op = o;
    e.tag = tag;
    case (o)
      2'b00: if (!d) begin s = a + b + c; e.r = 16'(s); e.c = (s > 65535); end
             else begin s = bcd2int(a) + bcd2int(b) + c; e.c = (s >= 10000); e.r = int2bcd(s % 10000); end
      2'b01: if (!d) begin s = int'(a) - int'(b) - (1 - c); e.c = (s >= 0); e.r = 16'(s); end
             else begin s = bcd2int(a) - bcd2int(b) - (1 - c); e.c = (s >= 0);
                        e.r = int2bcd(s < 0 ? s + 10000 : s); end
      2'b10: begin e.r = {c, a[15:1]}; e.c = a[0]; end
      default: begin e.r = a; e.c = c; end
    endcase
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (res !== e.r || cout !== e.c) begin
        errors++;
        $display("FAIL %s: result %h carry %b, expected %h carry %b", e.tag, res, cout, e.r, e.c);
      end
      checks++;
      if (zf !== (e.r == 16'h0) || sf !== e.r[15]) begin
        errors++;
        $display("FAIL R7/R8 flags (%s): zero %b sign %b, expected zero %b sign %b",
                 e.tag, zf, sf, (e.r == 16'h0), e.r[15]);
      end
    end
  end

  initial begin
    acc = '0; opb = '0; cin = 1'b0; dec = 1'b0; op = 2'b00;
    repeat (3) @(negedge clk);
    checks++;
    if (res !== 16'h0 || cout !== 1'b0 || zf !== 1'b1 || sf !== 1'b0) begin
      errors++;
      $display("FAIL R7 idle: result %h carry %b zero %b, expected 0000 0 1", res, cout, zf);
    end
    rst_n = 1'b1;
    // R1 binary add
    drive(2'b00, 0, 16'h1234, 16'h4321, 0, "R1 plain add");
    drive(2'b00, 0, 16'h1234, 16'h4321, 1, "R1 add carry in");
    drive(2'b00, 0, 16'hFFFF, 16'h0001, 0, "R1 wrap to zero");
    drive(2'b00, 0, 16'h7FFF, 16'h0000, 1, "R1 into sign bit");
    drive(2'b00, 0, 16'h0009, 16'h0001, 0, "R1 no decimal fix");
    // R2 binary subtract
    drive(2'b01, 0, 16'h5000, 16'h1234, 1, "R2 sub no borrow");
    drive(2'b01, 0, 16'h5000, 16'h1234, 0, "R2 sub extra unit");
    drive(2'b01, 0, 16'h0000, 16'h0001, 1, "R2 sub underflow");
    drive(2'b01, 0, 16'h1234, 16'h1234, 1, "R2 sub equal zero");
    drive(2'b01, 0, 16'h1234, 16'h1234, 0, "R2 sub equal borrow");
    // R3 decimal add
    drive(2'b00, 1, 16'h0009, 16'h0001, 0, "R3 digit carry");
    drive(2'b00, 1, 16'h9999, 16'h0001, 0, "R3 full ripple");
    drive(2'b00, 1, 16'h1258, 16'h4763, 1, "R3 mixed digits");
    drive(2'b00, 1, 16'h0008, 16'h0008, 0, "R3 digit above nine");
    drive(2'b00, 1, 16'h5000, 16'h5000, 0, "R3 top carry out");
    drive(2'b00, 1, 16'h9999, 16'h9999, 1, "R3 max sum");
    // R4 decimal subtract
    drive(2'b01, 1, 16'h0000, 16'h0001, 1, "R4 borrow all digits");
    drive(2'b01, 1, 16'h1000, 16'h0001, 1, "R4 borrow ripple");
    drive(2'b01, 1, 16'h4321, 16'h1234, 1, "R4 mixed");
    drive(2'b01, 1, 16'h4321, 16'h1234, 0, "R4 carry zero");
    drive(2'b01, 1, 16'h0050, 16'h0050, 1, "R4 equal zero");
    drive(2'b01, 1, 16'h0050, 16'h0050, 0, "R4 equal borrow");
    // R5 rotate
    drive(2'b10, 0, 16'h8001, 16'hFFFF, 0, "R5 rotate c0");
    drive(2'b10, 1, 16'h8001, 16'h1234, 1, "R5 rotate c1 decimal ignored");
    drive(2'b10, 1, 16'h0001, 16'h0000, 0, "R5 rotate to zero");
    // R6 pass
    drive(2'b11, 0, 16'hA5A5, 16'h1111, 1, "R6 pass");
    drive(2'b11, 1, 16'h0000, 16'hFFFF, 0, "R6 pass zero");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule